// File: doc/BRIEF.md
# DMA Stream Transfer Sequencer

This block holds the control state for one DMA stream. A start pulse captures a configuration: two base addresses, a second memory-side base, an item count, per-side transfer size and increment choice, and the mode bits. After that the block tracks the transfer one item at a time. The bus engine that moves the data pulses `item_done` once for each item it completes. For every pulse the sequencer steps the source and destination addresses, counts the remaining items down, and decides when the transfer has finished.

The transfer can end in two ways. With DMA flow control the programmed count reaches its last item. With peripheral flow control the peripheral marks the last item itself. When a DMA-flow transfer ends in circular or double-buffer mode, the block reloads the count and the addresses and the stream stays enabled. In double-buffer mode the memory side also swaps to the other of its two buffers. Five sticky event flags record the half-transfer point, completion, a transfer error, a FIFO error and a direct-mode error. Each flag has an enable, and the enabled flags are ORed into one interrupt line.

Top module: `dma_stream_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output register clears: `active`, `remaining`, both addresses, `buf_sel` and `flags` go to 0, and `irq` is therefore 0.
- R2: A `go` pulse while idle starts the stream on the next edge. The start is accepted in DMA flow mode (`cfg_pfc`=0) only with a count from 1 to 65535; in peripheral flow mode any count is accepted. On start, the addresses load from `cfg_src_addr`/`cfg_dst_addr`, `remaining` loads the count (65535 in peripheral flow mode) and `buf_sel` goes to 0. A `go` with count 0 in DMA flow mode is ignored, and so is a `go` while `active`.
- R3: Each `item_done` while active, without a transfer error, lowers `remaining` by one. It also moves each address whose increment bit is set by the size of that side: size code 0 moves 1 byte, code 1 moves 2 bytes, codes 2 and 3 move 4 bytes. An address whose increment bit is clear stays fixed.
- R4: In DMA flow mode, the item taken at `remaining`=1 completes the transfer. It sets flag bit 1 (transfer complete), and if neither `cfg_circ` nor `cfg_dbuf` was set, `active` drops on that edge.
- R5: In circular mode, completion reloads `remaining` with the programmed count and both addresses with their bases, and `active` stays 1.
- R6: In double-buffer mode, completion always reloads, whether or not `cfg_circ` is set, and toggles `buf_sel`. The memory side (the destination when `cfg_mem_dst`=1, otherwise the source) loads `cfg_alt_addr` when `buf_sel` becomes 1 and its own base when it becomes 0. The other side reloads its base.
- R7: In DMA flow mode, flag bit 0 (half transfer) sets on the first item of each pass after which 2·`remaining` ≤ programmed count. With a count of 1, it sets in the same edge as the completion flag.
- R8: In peripheral flow mode, an `item_done` with `periph_last` high completes the transfer and sets flag bit 1. The half flag never sets in this mode, and the stream always stops, whatever `cfg_circ` and `cfg_dbuf` say.
- R9: `xfer_err` while active sets flag bit 2 and clears `active` on the same edge. An `item_done` in that cycle is not counted, and the addresses do not move.
- R10: `fifo_err` and `direct_err` while active set flag bits 3 and 4. The stream keeps running.
- R11: Flags are sticky until their `flag_clr` bit is pulsed. A set and a clear of the same bit in one cycle leave it set. Error inputs have no effect while idle.
- R12: `irq` is high exactly when some `flags[i]` and `irq_en[i]` are both 1. It is combinational, so it follows `irq_en` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start pulse; captures the configuration |
| cfg_src_addr | input | 32 | Source base address |
| cfg_dst_addr | input | 32 | Destination base address |
| cfg_alt_addr | input | 32 | Second memory-side buffer base |
| cfg_count | input | 16 | Item count (DMA flow mode) |
| cfg_src_size | input | 2 | Source size code (0 byte, 1 half, 2/3 word) |
| cfg_dst_size | input | 2 | Destination size code |
| cfg_src_inc | input | 1 | Source address increments |
| cfg_dst_inc | input | 1 | Destination address increments |
| cfg_pfc | input | 1 | Peripheral flow control |
| cfg_circ | input | 1 | Circular reload |
| cfg_dbuf | input | 1 | Memory-side double buffering |
| cfg_mem_dst | input | 1 | 1: destination is the memory side |
| item_done | input | 1 | One item completed |
| periph_last | input | 1 | Peripheral marks the last item |
| xfer_err | input | 1 | Bus transfer error |
| fifo_err | input | 1 | FIFO error event |
| direct_err | input | 1 | Direct-mode error event |
| flag_clr | input | 5 | Per-flag clear |
| irq_en | input | 5 | Per-flag interrupt enable |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| remaining | output | 16 | Items left |
| buf_sel | output | 1 | Active memory buffer index |
| active | output | 1 | Stream enabled |
| flags | output | 5 | Event flags: half, complete, transfer error, FIFO error, direct error |
| irq | output | 1 | Combined interrupt |

## Verification
Two events can land in the same edge. With a count of 1, the half-transfer point and completion fall on the same item, and the bench checks that both flags set together. A flag clear arriving in the same cycle as that flag's set is driven on purpose, and the flag must stay set. An `item_done` coincident with `xfer_err` must leave the count and addresses untouched while the stream stops. A behavioural model in the bench predicts every output on every clock.

// File: rtl/dma_seq_pkg.sv
// Shared constants, types and helpers for the DMA stream sequencer.
// Assumes the five-flag layout below is fixed; the bit positions are visible at the ports.
package dma_seq_pkg;
    localparam int NUM_FLAGS  = 5;
    localparam int FLG_HALF   = 0;
    localparam int FLG_DONE   = 1;
    localparam int FLG_XERR   = 2;
    localparam int FLG_FIFO   = 3;
    localparam int FLG_DIRECT = 4;

    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_WIDE = 2'd3} xfer_size_e;

    typedef struct packed {
        logic pfc;
        logic circ;
        logic dbuf;
        logic mem_dst;
    } mode_t;

    // Byte step for a size code; the spare code behaves as a word.
    function automatic logic [2:0] size_step(input logic [1:0] code);
        case (xfer_size_e'(code))
            SZ_BYTE: size_step = 3'd1;
            SZ_HALF: size_step = 3'd2;
            default: size_step = 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/dma_seq_addr.sv
// Address generator for one side of a stream.
// Captures its base, alternate base, step and increment choice on load.
// On reload it returns to the base, or to the alternate base when this side
// is the double-buffered memory side and the next buffer is 1.
// Assumes load and reload never arrive in the same cycle.
module dma_seq_addr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [ADDR_W-1:0] alt_in,
    input  logic              inc_in,
    input  logic [1:0]        size_in,
    input  logic              dbuf_side,
    input  logic              adv,
    input  logic              reload,
    input  logic              reload_buf,
    output logic [ADDR_W-1:0] addr
);
    import dma_seq_pkg::*;

    logic [ADDR_W-1:0] base_r, alt_r;
    logic [2:0]        step_r;
    logic              inc_r;

    // Capture the per-side configuration at stream start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_r <= '0;
            alt_r  <= '0;
            step_r <= 3'd0;
            inc_r  <= 1'b0;
        end else if (load) begin
            base_r <= base_in;
            alt_r  <= alt_in;
            step_r <= size_step(size_in);
            inc_r  <= inc_in;
        end
    end

    // Advance, reload or load the current address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= base_in;
        end else if (reload) begin
            addr <= (dbuf_side && reload_buf) ? alt_r : base_r;
        end else if (adv && inc_r) begin
            addr <= addr + ADDR_W'(step_r);
        end
    end

    AST_ADDR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !reload && !load && !inc_r) |=> addr == $past(addr)); // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !reload && !load && inc_r) |=> addr == $past(addr) + ADDR_W'($past(step_r))); // R3
endmodule

// File: rtl/dma_seq_count.sv
// Remaining-item counter with completion and half-point detection.
// The programmed total is kept so that circular and double-buffer passes can reload it.
// The half point fires once per pass, on the first item that leaves twice the
// remaining count at or below the total.
// Assumes adv is only raised while the stream is active.
module dma_seq_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] init,
    input  logic             half_en,
    input  logic             adv,
    input  logic             last_in,
    input  logic             reload,
    output logic [CNT_W-1:0] remaining,
    output logic             finish,
    output logic             half_hit
);
    logic [CNT_W-1:0] total_r;
    logic             armed_r;
    logic [CNT_W-1:0] rem_m1;

    assign rem_m1   = remaining - CNT_W'(1);
    assign finish   = adv && ((remaining == CNT_W'(1)) || last_in);
    assign half_hit = adv && half_en && armed_r && ({rem_m1, 1'b0} <= {1'b0, total_r});

    // Count items down; restore the total on load or reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
            total_r   <= '0;
        end else if (load) begin
            remaining <= init;
            total_r   <= init;
        end else if (reload) begin
            remaining <= total_r;
        end else if (adv) begin
            remaining <= rem_m1;
        end
    end

    // One half-point event per pass; re-armed at the start of each pass.
    always_ff @(posedge clk) begin
        if (!rst_n)                armed_r <= 1'b0;
        else if (load || reload)   armed_r <= 1'b1;
        else if (half_hit)         armed_r <= 1'b0;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !reload && !load) |=> remaining == $past(remaining) - CNT_W'(1)); // R3
    AST_HALF_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (half_hit && !reload) |=> !half_hit); // R7
endmodule

// File: rtl/dma_seq_flags.sv
// Sticky event-flag bank with per-flag clear and enable, ORed into one interrupt.
// A set beats a clear of the same bit in the same cycle.
module dma_seq_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_in,
    input  logic [N-1:0] clr_in,
    input  logic [N-1:0] en_in,
    output logic [N-1:0] flags,
    output logic         irq
);
    for (genvar gi = 0; gi < N; gi++) begin : g_flag
        // Hold one flag: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          flags[gi] <= 1'b0;
            else if (set_in[gi]) flags[gi] <= 1'b1;
            else if (clr_in[gi]) flags[gi] <= 1'b0;
        end

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[gi] && !clr_in[gi]) |=> flags[gi]); // R11
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_in[gi] |=> flags[gi]); // R11
    end

    assign irq = |(flags & en_in);
endmodule

// File: rtl/dma_stream_seq.sv
// Top of the per-stream sequencer.
// Latches the mode on start, enables the stream, steers completion to stop or
// reload, swaps the memory buffer in double-buffer mode and feeds the flag bank.
// Assumes the bus engine raises item_done at most once per cycle, and only for
// items it actually moved.
module dma_stream_seq #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] cfg_src_addr,
    input  logic [ADDR_W-1:0] cfg_dst_addr,
    input  logic [ADDR_W-1:0] cfg_alt_addr,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [1:0]        cfg_src_size,
    input  logic [1:0]        cfg_dst_size,
    input  logic              cfg_src_inc,
    input  logic              cfg_dst_inc,
    input  logic              cfg_pfc,
    input  logic              cfg_circ,
    input  logic              cfg_dbuf,
    input  logic              cfg_mem_dst,
    input  logic              item_done,
    input  logic              periph_last,
    input  logic              xfer_err,
    input  logic              fifo_err,
    input  logic              direct_err,
    input  logic [4:0]        flag_clr,
    input  logic [4:0]        irq_en,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CNT_W-1:0]  remaining,
    output logic              buf_sel,
    output logic              active,
    output logic [4:0]        flags,
    output logic              irq
);
    import dma_seq_pkg::*;

    localparam int NSIDE = 2;

    mode_t            mode_r;
    logic             load, adv, finish, half_hit, reload, reload_buf;
    logic [CNT_W-1:0] init_cnt;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [ADDR_W-1:0]    addr_q [NSIDE];

    assign load       = go && !active && (cfg_pfc || (cfg_count != '0));
    assign init_cnt   = cfg_pfc ? '1 : cfg_count;
    assign adv        = active && item_done && !xfer_err;
    assign reload     = finish && !mode_r.pfc && (mode_r.circ || mode_r.dbuf);
    assign reload_buf = mode_r.dbuf ? ~buf_sel : buf_sel;

    // Capture the operating mode at stream start.
    always_ff @(posedge clk) begin
        if (!rst_n)    mode_r <= '0;
        else if (load) mode_r <= '{pfc: cfg_pfc, circ: cfg_circ, dbuf: cfg_dbuf, mem_dst: cfg_mem_dst};
    end

    // Stream enable: set on start, cleared by a transfer error or a final completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                      active <= 1'b0;
        else if (load)                   active <= 1'b1;
        else if (active && xfer_err)     active <= 1'b0;
        else if (finish && !reload)      active <= 1'b0;
    end

    // Memory buffer index: zero at start, toggles at each double-buffer reload.
    always_ff @(posedge clk) begin
        if (!rst_n)                      buf_sel <= 1'b0;
        else if (load)                   buf_sel <= 1'b0;
        else if (reload && mode_r.dbuf)  buf_sel <= ~buf_sel;
    end

    dma_seq_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .init      (init_cnt),
        .half_en   (!mode_r.pfc),
        .adv       (adv),
        .last_in   (mode_r.pfc && periph_last),
        .reload    (reload),
        .remaining (remaining),
        .finish    (finish),
        .half_hit  (half_hit)
    );

    for (genvar gi = 0; gi < NSIDE; gi++) begin : g_side
        localparam bit IS_DST = (gi == 1);
        dma_seq_addr #(.ADDR_W(ADDR_W)) u_addr (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load),
            .base_in    (IS_DST ? cfg_dst_addr : cfg_src_addr),
            .alt_in     (cfg_alt_addr),
            .inc_in     (IS_DST ? cfg_dst_inc : cfg_src_inc),
            .size_in    (IS_DST ? cfg_dst_size : cfg_src_size),
            .dbuf_side  (mode_r.dbuf && (mode_r.mem_dst == IS_DST)),
            .adv        (adv),
            .reload     (reload),
            .reload_buf (reload_buf),
            .addr       (addr_q[gi])
        );
    end

    assign src_addr = addr_q[0];
    assign dst_addr = addr_q[1];

    always_comb begin
        flag_set             = '0;
        flag_set[FLG_HALF]   = half_hit;
        flag_set[FLG_DONE]   = finish;
        flag_set[FLG_XERR]   = active && xfer_err;
        flag_set[FLG_FIFO]   = active && fifo_err;
        flag_set[FLG_DIRECT] = active && direct_err;
    end

    dma_seq_flags #(.N(NUM_FLAGS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_in (flag_set),
        .clr_in (flag_clr),
        .en_in  (irq_en),
        .flags  (flags),
        .irq    (irq)
    );

    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && xfer_err) |=> !active); // R9
    AST_RELOAD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> active); // R5
    AST_BUF_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && mode_r.dbuf) |=> buf_sel != $past(buf_sel)); // R6
    AST_BUSY_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (active && go && !item_done && !xfer_err) |=> remaining == $past(remaining)); // R2
    AST_PFC_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && mode_r.pfc) |=> !active); // R8
endmodule

// File: tb/dma_stream_seq_tb.sv
`timescale 1ns/1ps
module dma_stream_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [31:0] cfg_src_addr = '0, cfg_dst_addr = '0, cfg_alt_addr = '0;
    logic [15:0] cfg_count = '0;
    logic [1:0]  cfg_src_size = '0, cfg_dst_size = '0;
    logic        cfg_src_inc = 0, cfg_dst_inc = 0, cfg_pfc = 0, cfg_circ = 0, cfg_dbuf = 0, cfg_mem_dst = 0;
    logic        item_done = 0, periph_last = 0, xfer_err = 0, fifo_err = 0, direct_err = 0;
    logic [4:0]  flag_clr = '0, irq_en = '0;
    logic [31:0] src_addr, dst_addr;
    logic [15:0] remaining;
    logic        buf_sel, active, irq;
    logic [4:0]  flags;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 0;

    always #4 clk = ~clk;  // 125 MHz

    dma_stream_seq dut_i (
        .clk(clk), .rst_n(rst_n), .go(go),
        .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr), .cfg_alt_addr(cfg_alt_addr),
        .cfg_count(cfg_count), .cfg_src_size(cfg_src_size), .cfg_dst_size(cfg_dst_size),
        .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc), .cfg_pfc(cfg_pfc),
        .cfg_circ(cfg_circ), .cfg_dbuf(cfg_dbuf), .cfg_mem_dst(cfg_mem_dst),
        .item_done(item_done), .periph_last(periph_last), .xfer_err(xfer_err),
        .fifo_err(fifo_err), .direct_err(direct_err), .flag_clr(flag_clr), .irq_en(irq_en),
        .src_addr(src_addr), .dst_addr(dst_addr), .remaining(remaining),
        .buf_sel(buf_sel), .active(active), .flags(flags), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_src, m_dst, m_sbase, m_dbase, m_alt;
    int          m_rem, m_total, m_sstep, m_dstep;
    bit          m_act, m_buf, m_armed, m_sinc, m_dinc, m_pfc, m_circ, m_dbuf, m_mdst;
    logic [4:0]  m_flags;

    function automatic int step_of(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_src = 0; m_dst = 0; m_rem = 0; m_act = 0; m_buf = 0; m_flags = 0; m_armed = 0;
            m_pfc = 0; m_circ = 0; m_dbuf = 0; m_mdst = 0; m_total = 0;
        end else begin
            bit adv, fin, rl, ht, nb;
            logic [4:0] setv;
            adv  = m_act && item_done && !xfer_err;
            fin  = adv && (m_rem == 1 || (m_pfc && periph_last));
            rl   = fin && !m_pfc && (m_circ || m_dbuf);
            ht   = adv && !m_pfc && m_armed && (2 * (m_rem - 1) <= m_total);
            setv = {m_act && direct_err, m_act && fifo_err, m_act && xfer_err, fin, ht};
            m_flags = setv | (m_flags & ~flag_clr);
            nb = m_dbuf ? !m_buf : m_buf;
            if (go && !m_act && (cfg_pfc || cfg_count != 0)) begin
                m_act = 1; m_buf = 0; m_armed = 1;
                m_rem = cfg_pfc ? 65535 : int'(cfg_count); m_total = m_rem;
                m_sbase = cfg_src_addr; m_dbase = cfg_dst_addr; m_alt = cfg_alt_addr;
                m_src = cfg_src_addr; m_dst = cfg_dst_addr;
                m_sstep = step_of(cfg_src_size); m_dstep = step_of(cfg_dst_size);
                m_sinc = cfg_src_inc; m_dinc = cfg_dst_inc;
                m_pfc = cfg_pfc; m_circ = cfg_circ; m_dbuf = cfg_dbuf; m_mdst = cfg_mem_dst;
            end else if (m_act && xfer_err) begin
                m_act = 0;
            end else if (adv) begin
                if (ht) m_armed = 0;
                if (rl) begin
                    m_rem = m_total; m_armed = 1;
                    m_src = (m_dbuf && !m_mdst && nb) ? m_alt : m_sbase;
                    m_dst = (m_dbuf &&  m_mdst && nb) ? m_alt : m_dbase;
                    m_buf = nb;
                end else begin
                    m_rem = m_rem - 1;
                    if (m_sinc) m_src = m_src + 32'(m_sstep);
                    if (m_dinc) m_dst = m_dst + 32'(m_dstep);
                    if (fin) m_act = 0;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R3 remaining vs model", 64'(remaining), 64'(m_rem));
            chk("R3 src_addr vs model", 64'(src_addr), 64'(m_src));
            chk("R3 dst_addr vs model", 64'(dst_addr), 64'(m_dst));
            chk("R6 buf_sel vs model", 64'(buf_sel), 64'(m_buf));
            chk("R2 active vs model", 64'(active), 64'(m_act));
            chk("R11 flags vs model", 64'(flags), 64'(m_flags));
            chk("R12 irq vs model", 64'(irq), 64'(|(m_flags & irq_en)));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic pulse_go();
        @(negedge clk); #1 go = 1;
        @(negedge clk); #1 go = 0;
    endtask

    task automatic items(input int n, input bit last_on_final);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1 item_done = 1; periph_last = last_on_final && (i == n - 1);
            @(negedge clk); #1 item_done = 0; periph_last = 0;
        end
    endtask

    task automatic items_burst(input int n);
        @(negedge clk); #1 item_done = 1;
        repeat (n) @(negedge clk);
        #1 item_done = 0;
    endtask

    task automatic err_pulse(input bit xe, input bit fe, input bit de, input bit with_item);
        @(negedge clk); #1 xfer_err = xe; fifo_err = fe; direct_err = de; item_done = with_item;
        @(negedge clk); #1 xfer_err = 0; fifo_err = 0; direct_err = 0; item_done = 0;
    endtask

    task automatic clear_all();
        @(negedge clk); #1 flag_clr = 5'h1f;
        @(negedge clk); #1 flag_clr = 5'h00;
    endtask

    task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] a,
                         input logic [15:0] n, input logic [1:0] ss, input logic [1:0] ds,
                         input bit si, input bit di, input bit pfc, input bit circ,
                         input bit dbuf, input bit mdst);
        cfg_src_addr = s; cfg_dst_addr = d; cfg_alt_addr = a; cfg_count = n;
        cfg_src_size = ss; cfg_dst_size = ds; cfg_src_inc = si; cfg_dst_inc = di;
        cfg_pfc = pfc; cfg_circ = circ; cfg_dbuf = dbuf; cfg_mem_dst = mdst;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset active", 64'(active), 0);
        chk("R1 reset remaining", 64'(remaining), 0);
        chk("R1 reset flags/irq", 64'({flags, irq, buf_sel}), 0);
        chk("R1 reset addresses", 64'({src_addr, dst_addr}), 0);
        #1 rst_n = 1; cmp_on = 1;

        // Plain DMA-flow transfer: word source increments, byte destination fixed.
        setup(32'h1000, 32'h2000, 32'h0, 16'd4, 2'd2, 2'd0, 1, 0, 0, 0, 0, 0);
        pulse_go();
        chk("R2 start loads count", 64'(remaining), 4);
        chk("R2 start active", 64'(active), 1);
        items(2, 0);
        chk("R7 half flag at 2 of 4", 64'(flags[0]), 1);
        items(2, 0);
        chk("R3 src stepped by word", 64'(src_addr), 64'h1010);
        chk("R3 fixed dst", 64'(dst_addr), 64'h2000);
        chk("R4 stops at completion", 64'(active), 0);
        chk("R4 complete flag", 64'(flags[1:0]), 64'h3);
        clear_all();
        chk("R11 clear flags", 64'(flags), 0);

        // Zero count in DMA flow mode is ignored.
        setup(32'h10, 32'h20, 32'h0, 16'd0, 2'd0, 2'd0, 1, 1, 0, 0, 0, 0);
        pulse_go();
        chk("R2 zero count ignored", 64'(active), 0);

        // Circular pass of 3 half-words.
        setup(32'h100, 32'h300, 32'h0, 16'd3, 2'd1, 2'd3, 1, 1, 0, 1, 0, 0);
        pulse_go();
        items(3, 0);
        chk("R5 circular reload count", 64'(remaining), 3);
        chk("R5 circular reload src", 64'(src_addr), 64'h100);
        chk("R5 circular stays active", 64'(active), 1);
        setup(32'h0, 32'h0, 32'h0, 16'd9, 2'd0, 2'd0, 0, 0, 0, 0, 0, 0);
        pulse_go();
        chk("R2 go while active ignored", 64'(remaining), 3);
        items(1, 0);
        chk("R3 dst wide code steps 4", 64'(dst_addr), 64'h304);
        err_pulse(1, 0, 0, 1);
        chk("R9 error item not counted", 64'(remaining), 2);
        chk("R9 error stops", 64'(active), 0);
        chk("R9 error flag", 64'(flags[2]), 1);
        clear_all();

        // Double buffering, memory on destination side, back-to-back items.
        setup(32'h40, 32'h4000, 32'h8000, 16'd2, 2'd2, 2'd2, 0, 1, 0, 0, 1, 1);
        pulse_go();
        items_burst(2);
        chk("R6 buffer swaps to 1", 64'(buf_sel), 1);
        chk("R6 memory side on alt", 64'(dst_addr), 64'h8000);
        chk("R6 peripheral side base", 64'(src_addr), 64'h40);
        items_burst(2);
        chk("R6 buffer back to 0", 64'(buf_sel), 0);
        chk("R6 memory side on base", 64'(dst_addr), 64'h4000);
        items(1, 0);
        chk("R6 dst steps in buffer", 64'(dst_addr), 64'h4004);
        err_pulse(1, 0, 0, 0);
        clear_all();

        // Double buffering on the source side.
        setup(32'h500, 32'h600, 32'h900, 16'd1, 2'd0, 2'd0, 1, 1, 0, 0, 1, 0);
        pulse_go();
        items(1, 0);
        chk("R6 source side takes alt", 64'(src_addr), 64'h900);
        err_pulse(1, 0, 0, 0);
        clear_all();

        // Count 1: half and completion in the same edge; clear collides with set.
        setup(32'h0, 32'h0, 32'h0, 16'd1, 2'd0, 2'd0, 0, 0, 0, 0, 0, 0);
        pulse_go();
        items(1, 0);
        chk("R7 half with complete", 64'(flags[1:0]), 64'h3);
        pulse_go();
        @(negedge clk); #1 item_done = 1; flag_clr = 5'b00011;
        @(negedge clk); #1 item_done = 0; flag_clr = 5'b00000;
        chk("R11 set beats clear", 64'(flags[1:0]), 64'h3);
        clear_all();

        // Peripheral flow control ends on the peripheral's mark, ignoring circular.
        setup(32'h700, 32'h800, 32'h0, 16'd0, 2'd1, 2'd1, 1, 1, 1, 1, 1, 1);
        pulse_go();
        chk("R8 pfc count loads max", 64'(remaining), 65535);
        items(5, 1);
        chk("R8 pfc remaining", 64'(remaining), 65530);
        chk("R8 pfc stops", 64'(active), 0);
        chk("R8 pfc flags complete only", 64'(flags[1:0]), 64'h2);
        clear_all();

        // FIFO and direct-mode errors keep the stream running; interrupt gating.
        setup(32'h0, 32'h0, 32'h0, 16'd5, 2'd0, 2'd0, 1, 1, 0, 0, 0, 0);
        pulse_go();
        err_pulse(0, 1, 0, 1);
        chk("R10 fifo flag", 64'(flags[3]), 1);
        chk("R10 stream runs", 64'({active, remaining}), 64'h10004);
        err_pulse(0, 0, 1, 0);
        chk("R10 direct flag", 64'(flags[4]), 1);
        @(negedge clk); #1 irq_en = 5'b01000;
        #1 chk("R12 irq enabled", 64'(irq), 1);
        irq_en = 5'b00111;
        #1 chk("R12 irq masked", 64'(irq), 0);
        irq_en = 5'b00000;
        err_pulse(1, 0, 0, 0);
        clear_all();
        err_pulse(1, 1, 1, 0);
        chk("R11 idle errors ignored", 64'(flags), 0);

        // Reset mid-transfer.
        pulse_go();
        items(1, 0);
        @(negedge clk); #1 rst_n = 0;
        @(negedge clk);
        chk("R1 reset clears running stream", 64'({active, remaining}), 0);
        #1 rst_n = 1;
        repeat (2) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule